// File: doc/BRIEF.md
# Unaligned-Address Write Strobe Generator

This block turns a single byte-addressed write request into one AXI4-Lite write on a 32-bit data path. It rounds the requested address down to a word boundary for the address channel. From the byte offset it builds a byte-enable mask that covers the lane at the offset and every lane above it. Data lanes below the offset are left out of the write, and they are driven with a fixed fill byte so that the bus never carries undefined values. The data is never shifted between lanes.

A requester presents an address and a data word with a valid flag. The block takes the request only while it is idle. After that it drives the address and write-data channels until each one sees its ready, then waits for the write response. Only one write is in flight at a time, and the `busy` output reports that state. Writes that cross a word boundary are not split into two beats.

Top module: `ustrb_gen`

## Requirements
- R1: A request whose byte offset (address bits [1:0]) is 0 drives wstrb = 4'b1111, where bit i enables data byte lane i (wdata[8i+7:8i]).
- R2: A byte offset of 1 drives wstrb = 4'b1110.
- R3: A byte offset of 2 drives wstrb = 4'b1100.
- R4: A byte offset of 3 drives wstrb = 4'b1000.
- R5: awaddr equals the requested address with bits [1:0] forced to zero, and all upper bits are passed through unchanged.
- R6: Each lane whose strobe bit is 1 carries the request's byte for that lane unchanged. Each lane whose strobe bit is 0 carries the fill byte (default 8'h00).
- R7: Once awvalid rises, it stays high with awaddr unchanged until the cycle in which awready is sampled high. It falls on the next clock edge.
- R8: Once wvalid rises, it stays high with wdata and wstrb unchanged until wready is sampled high. It falls on the next clock edge.
- R9: A request is taken on a clock edge where req_valid and req_ready are both high. On the next cycle busy is 1 and awvalid and wvalid are 1. req_ready stays 0 and further requests are ignored until the edge where bvalid and bready are both high. One cycle after that edge, busy is 0 again.
- R10: bready is 1 only after both the address and the data handshakes have completed, and it stays 1 until the response is accepted.
- R11: While rst_n is low, and directly after it, awvalid, wvalid, bready and busy are 0 and req_ready is 1. A reset in the middle of a transfer drops all valid outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_addr | input | 32 | Requested byte address |
| req_data | input | 32 | Requested data word, lane i in bits [8i+7:8i] |
| req_ready | output | 1 | Block is idle and takes a request |
| busy | output | 1 | A write is in flight |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awaddr | output | 32 | Word-aligned write address |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| wdata | output | 32 | Write data with fill in disabled lanes |
| wstrb | output | 4 | Byte-lane enables |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |

## Verification
Several rules are checked by assertions on every cycle:
- the address and data channels keep valid and payload steady while stalled;
- the address stays aligned;
- the strobe is always a contiguous run from the top lane downward;
- every disabled lane holds the fill byte;
- the response ready never appears while either channel is still pending;
- busy follows acceptance and response.

Other behaviour can only be shown by the bench's scenarios:
- the exact strobe chosen for each offset;
- the byte-exact data in the enabled lanes;
- that requests pushed in while busy leave no trace;
- that a reset in mid-transfer clears the channels.

// File: rtl/ustrb_pkg.sv
package ustrb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_RESP = 2'd2
  } txn_state_t;

  // A lane takes part in the write when it sits at or above the byte offset.
  function automatic logic lane_on(input int lane, input int offset);
    return (lane >= offset);
  endfunction

  // Clears the offset bits of a byte address.
  function automatic logic [63:0] align_down(input logic [63:0] addr, input int off_bits);
    logic [63:0] keep;
    keep = '1;
    keep = keep << off_bits;
    return addr & keep;
  endfunction

endpackage

// File: rtl/ustrb_lane_calc.sv
module ustrb_lane_calc #(
  parameter int          ADDR_W = 32,
  parameter int          DATA_W = 32,
  parameter logic [7:0]  FILL   = 8'h00,
  localparam int         LANES  = DATA_W / 8,
  localparam int         OFF_W  = $clog2(LANES)
) (
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic [ADDR_W-1:0] al_addr,
  output logic [LANES-1:0]  strb,
  output logic [DATA_W-1:0] mdata
);

  logic [OFF_W-1:0] offset;
  logic [63:0]      addr_wide;
  logic [63:0]      addr_al_wide;

  assign offset       = req_addr[OFF_W-1:0];
  assign addr_wide    = 64'(req_addr);
  assign addr_al_wide = ustrb_pkg::align_down(addr_wide, OFF_W);
  assign al_addr      = addr_al_wide[ADDR_W-1:0];

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      strb[i] = ustrb_pkg::lane_on(i, int'(offset));
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mdata[8*g +: 8] = strb[g] ? req_data[8*g +: 8] : FILL;
  end

  logic [63-ADDR_W:0] unused_hi;
  assign unused_hi = addr_al_wide[63:ADDR_W];

endmodule

// File: rtl/ustrb_chan_hold.sv
module ustrb_chan_hold #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] payload,
  output logic         fire
);

  assign fire = valid & ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      payload <= '0;
    end else if (load) begin
      valid   <= 1'b1;
      payload <= load_val;
    end else if (fire) begin
      valid   <= 1'b0;
    end
  end

  AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(payload)); // R7 R8

  AST_CHAN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !load |=> !valid); // R7 R8

endmodule

// File: rtl/ustrb_txn_ctrl.sv
module ustrb_txn_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic aw_valid,
  input  logic aw_fire,
  input  logic w_valid,
  input  logic w_fire,
  input  logic b_valid,
  output logic req_ready,
  output logic accept,
  output logic b_ready,
  output logic busy
);
  import ustrb_pkg::*;

  txn_state_t state, state_nx;
  logic       data_side_done;
  logic       resp_fire;

  assign data_side_done = (!aw_valid || aw_fire) && (!w_valid || w_fire);
  assign req_ready      = (state == ST_IDLE);
  assign accept         = req_ready && req_valid;
  assign b_ready        = (state == ST_RESP);
  assign resp_fire      = b_ready && b_valid;
  assign busy           = (state != ST_IDLE);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (accept)         state_nx = ST_XFER;
      ST_XFER: if (data_side_done) state_nx = ST_RESP;
      ST_RESP: if (resp_fire)      state_nx = ST_IDLE;
      default:                     state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && !req_ready); // R9

  AST_IDLE_AFTER_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    resp_fire |=> !busy); // R9

  AST_BREADY_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    b_ready |-> !aw_valid && !w_valid); // R10

  AST_BREADY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    b_ready && !b_valid |=> b_ready); // R10

endmodule

// File: rtl/ustrb_gen.sv
module ustrb_gen #(
  parameter int         ADDR_W = 32,
  parameter int         DATA_W = 32,
  parameter logic [7:0] FILL   = 8'h00,
  localparam int        LANES  = DATA_W / 8,
  localparam int        OFF_W  = $clog2(LANES),
  localparam int        WPAY_W = DATA_W + LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              req_ready,
  output logic              busy,
  output logic              awvalid,
  input  logic              awready,
  output logic [ADDR_W-1:0] awaddr,
  output logic              wvalid,
  input  logic              wready,
  output logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  wstrb,
  input  logic              bvalid,
  output logic              bready
);

  logic [ADDR_W-1:0] calc_addr;
  logic [LANES-1:0]  calc_strb;
  logic [DATA_W-1:0] calc_data;
  logic              accept;
  logic              aw_fire;
  logic              w_fire;
  logic [WPAY_W-1:0] w_payload;

  ustrb_lane_calc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FILL(FILL)) u_calc (
    .req_addr (req_addr),
    .req_data (req_data),
    .al_addr  (calc_addr),
    .strb     (calc_strb),
    .mdata    (calc_data)
  );

  ustrb_chan_hold #(.W(ADDR_W)) u_aw (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (calc_addr),
    .ready    (awready),
    .valid    (awvalid),
    .payload  (awaddr),
    .fire     (aw_fire)
  );

  ustrb_chan_hold #(.W(WPAY_W)) u_w (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val ({calc_strb, calc_data}),
    .ready    (wready),
    .valid    (wvalid),
    .payload  (w_payload),
    .fire     (w_fire)
  );

  assign wstrb = w_payload[WPAY_W-1:DATA_W];
  assign wdata = w_payload[DATA_W-1:0];

  ustrb_txn_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .aw_valid  (awvalid),
    .aw_fire   (aw_fire),
    .w_valid   (wvalid),
    .w_fire    (w_fire),
    .b_valid   (bvalid),
    .req_ready (req_ready),
    .accept    (accept),
    .b_ready   (bready),
    .busy      (busy)
  );

  // Checker-side view of the strobe: inverted mask must be a run of ones from bit 0.
  logic [LANES-1:0] inv_strb;
  logic [LANES-1:0] inv_overlap;
  assign inv_strb    = ~wstrb;
  assign inv_overlap = inv_strb & (inv_strb + LANES'(1));

  AST_AW_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid |-> awaddr[OFF_W-1:0] == '0); // R5

  AST_STRB_UPWARD: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid |-> wstrb[LANES-1] && inv_overlap == '0); // R4

  AST_VALID_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !awvalid && !wvalid && !bready); // R11

  for (genvar g = 0; g < LANES; g++) begin : g_fill_chk
    AST_FILL_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      wvalid && !wstrb[g] |-> wdata[8*g +: 8] == FILL); // R6
  end

endmodule

// File: tb/sim_ustrb_gen.sv
`timescale 1ns/1ps
module sim_ustrb_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic        req_ready, busy, awvalid, wvalid, bready;
  logic        awready = 1'b0, wready = 1'b0, bvalid = 1'b0;
  logic [31:0] awaddr, wdata;
  logic [3:0]  wstrb;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ustrb_gen u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .req_ready(req_ready), .busy(busy),
    .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
    .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb),
    .bvalid(bvalid), .bready(bready)
  );

  // Vector table: request address, request data, expected awaddr, wstrb, wdata.
  localparam logic [31:0] T_ADDR [8] = '{32'h0000_1000, 32'h0000_1001, 32'h0000_1002,
    32'h0000_1003, 32'hFFFF_FFFF, 32'h8000_0006, 32'h0000_000D, 32'h7654_3210};
  localparam logic [31:0] T_DATA [8] = '{32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'hDEAD_BEEF,
    32'hDEAD_BEEF, 32'h1234_5678, 32'hA5A5_C3C3, 32'hFFFF_FFFF, 32'h0102_0304};
  localparam logic [31:0] T_AW [8] = '{32'h0000_1000, 32'h0000_1000, 32'h0000_1000,
    32'h0000_1000, 32'hFFFF_FFFC, 32'h8000_0004, 32'h0000_000C, 32'h7654_3210};
  localparam logic [3:0]  T_STRB [8] = '{4'b1111, 4'b1110, 4'b1100, 4'b1000,
    4'b1000, 4'b1100, 4'b1110, 4'b1111};
  localparam logic [31:0] T_WD [8] = '{32'hDEAD_BEEF, 32'hDEAD_BE00, 32'hDEAD_0000,
    32'hDE00_0000, 32'h1200_0000, 32'hA5A5_0000, 32'hFFFF_FF00, 32'h0102_0304};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Offsets 0..3 map to R1..R4.
  function automatic string stag(input logic [1:0] off);
    case (off)
      2'd0:    return "R1";
      2'd1:    return "R2";
      2'd2:    return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic run_txn(input logic [31:0] a, input logic [31:0] d, input logic [31:0] exp_aw,
                         input logic [3:0] exp_s, input logic [31:0] exp_wd,
                         input int aw_dly, input int w_dly, input int b_dly, input bit poke);
    bit aw_done = 0;
    bit w_done  = 0;
    int c = 0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R9", 32'(busy), 32'd1);
    chk(req_ready == 1'b0, "R9", 32'(req_ready), 32'd0);
    forever begin
      if (awready) begin aw_done = 1; awready = 1'b0; end
      if (wready)  begin w_done  = 1; wready  = 1'b0; end
      if (aw_done && w_done) break;
      if (!aw_done) begin
        chk(awvalid == 1'b1, "R7", 32'(awvalid), 32'd1);
        chk(awaddr == exp_aw, "R5", awaddr, exp_aw);
      end else begin
        chk(awvalid == 1'b0, "R7", 32'(awvalid), 32'd0);
      end
      if (!w_done) begin
        chk(wvalid == 1'b1, "R8", 32'(wvalid), 32'd1);
        chk(wstrb == exp_s, stag(a[1:0]), 32'(wstrb), 32'(exp_s));
        chk(wdata == exp_wd, "R6", wdata, exp_wd);
      end else begin
        chk(wvalid == 1'b0, "R8", 32'(wvalid), 32'd0);
      end
      chk(bready == 1'b0, "R10", 32'(bready), 32'd0);
      if (poke) begin req_valid = 1'b1; req_addr = ~a; req_data = ~d; end
      awready = !aw_done && (c >= aw_dly);
      wready  = !w_done  && (c >= w_dly);
      @(negedge clk);
      c++;
      if (c > 20) break;
    end
    chk(awvalid == 1'b0 && wvalid == 1'b0, "R7", {awvalid, wvalid}, 32'd0);
    for (int k = 0; k <= b_dly; k++) begin
      chk(bready == 1'b1, "R10", 32'(bready), 32'd1);
      chk(busy == 1'b1, "R9", 32'(busy), 32'd1);
      if (k < b_dly) @(negedge clk);
    end
    req_valid = 1'b0;
    bvalid = 1'b1;
    @(negedge clk);
    bvalid = 1'b0;
    chk(busy == 1'b0 && req_ready == 1'b1, "R9", {busy, req_ready}, 32'd1);
    // A request pushed in while busy must not have started another write.
    chk(awvalid == 1'b0 && wvalid == 1'b0, "R9", {awvalid, wvalid}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R11: state during and right after reset
    repeat (3) @(negedge clk);
    chk(!awvalid && !wvalid && !bready && !busy, "R11",
        {awvalid, wvalid, bready, busy}, 32'd0);
    chk(req_ready == 1'b1, "R11", 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!awvalid && !wvalid && !busy, "R11", {awvalid, wvalid, busy}, 32'd0);

    for (int i = 0; i < 8; i++) begin
      run_txn(T_ADDR[i], T_DATA[i], T_AW[i], T_STRB[i], T_WD[i],
              i % 3, (i + 1) % 4, i % 2, (i % 2) == 1);
    end

    // Data ready before address ready, long stalls, all-ones data at offset 3 (R4, R6)
    run_txn(32'h0000_0007, 32'hFFFF_FFFF, 32'h0000_0004, 4'b1000, 32'hFF00_0000, 5, 0, 3, 1'b1);
    // Offset 1 with zero data: enabled lanes still 0, address rounds down (R2, R5)
    run_txn(32'h0000_0101, 32'h0000_0000, 32'h0000_0100, 4'b1110, 32'h0000_0000, 0, 6, 0, 1'b0);

    // R11: reset in the middle of a transfer
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h0000_2002; req_data = 32'h5555_AAAA;
    @(negedge clk);
    req_valid = 1'b0;
    chk(awvalid && wvalid, "R11", {awvalid, wvalid}, 32'd3);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!awvalid && !wvalid && !busy && !bready, "R11",
        {awvalid, wvalid, busy, bready}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11", 32'(req_ready), 32'd1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule